// File: doc/BRIEF.md
# Half-Band Decimate-by-Two Filter

This block is the second rate-reduction stage of a digital down-converter receive chain. It takes the signed sample stream produced by the integrator-comb decimator and halves its rate. The last low-pass shaping filter then takes its output. The filter is an 11-tap half-band FIR. Its pass edge and stop edge mirror each other about one quarter of the input sample rate, and its pass and stop ripple are equal. In this response every second coefficient is zero except the centre one.

The block exploits three properties of this filter. It never multiplies the zero-valued taps. It adds each pair of symmetric samples together before the single multiply that the pair shares. It evaluates the filter only for the samples that are kept, so the multipliers work once every two accepted inputs. The centre coefficient is exactly one half, so it is an arithmetic shift and needs no multiplier. The sum is kept at full precision. It is then rounded half-up to the output width and clipped to the signed output range.

Input samples come with a one-cycle valid strobe and may arrive on any cycle, with gaps. Each output is a single-cycle pulse on the output valid line, with the data held until the next pulse.

Top module: `hb_decim2`

## Requirements
- R1: While `rstN` is low, and immediately after, `outValid` is 0 and `outData` is 0. The delay line also clears to zero.
- R2: Only cycles with `inValid` high advance the filter. Counting accepted samples from reset, an output is produced after each even-numbered one (2nd, 4th, ...) and after no other. Cycles with `inValid` low neither shift data nor change the phase.
- R3: Number the accepted samples x[n]. The output after sample n is y = (sum over j=0..10 of h[j]*x[n-j]) / 32768, with x = 0 before reset release. The coefficients are h[0]=h[10]=310, h[2]=h[8]=-1772, h[4]=h[6]=9654 and h[5]=16384 (one half). h[1], h[3], h[7] and h[9] are zero.
- R4: `outValid` is high for exactly one cycle per output, and it is never high on two consecutive cycles.
- R5: Suppose `inValid` is high in cycle t with a pair-completing sample. Then `outValid` is high, with the matching result, in cycle t+4.
- R6: `outData` changes only in a cycle where `outValid` is high, and holds its value otherwise.
- R7: The full-precision sum S (in units of 1/32768) is rounded half-up, giving floor((S + 16384) / 32768). A fraction of exactly one half rounds toward plus infinity, so +0.5 gives 1 and -0.5 gives 0.
- R8: A rounded value above 2^(OUT_W-1)-1 or below -2^(OUT_W-1) is clipped to that limit.
- R9: The coefficient sum is exactly 1. Once 11 equal samples c have been accepted, every later output equals c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample strobe, one cycle per sample |
| inData | input | DATA_W | Signed input sample |
| outValid | output | 1 | One-cycle pulse marking a new output sample |
| outData | output | OUT_W | Signed filtered, decimated sample, held between pulses |

## Verification
Impulses placed on both input parities separate the centre shift path from the three pre-added product paths. They also confirm that the odd taps contribute nothing. Inputs of +1 and -1 in the centre position produce exact half-way fractions, which separates half-up rounding from truncation and from round-to-even. Constant runs confirm unity DC gain. Sign-matched full-scale sequences force both clip limits.

Long random streams with random gaps between valid strobes check the arithmetic and the pairing phase. They also check the fixed four-cycle output timing against a reference computed from the coefficient list.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Number of non-centre coefficient pairs is HB_K+1, tap count 4*HB_K+3.
  parameter int HB_K      = 2;
  parameter int COEF_W    = 16;
  parameter int COEF_FRAC = 15;

  localparam int NTAPS  = 4 * HB_K + 3;
  localparam int NPAIRS = HB_K + 1;
  localparam int CENTRE = (NTAPS - 1) / 2;

  typedef logic signed [COEF_W-1:0] coef_t;

  // Pair p covers taps 2p and NTAPS-1-2p (outermost pair first).
  // The values sum, doubled and with the centre half, to exactly one.
  function automatic coef_t pairCoef(input int p);
    case (p)
      0:       return coef_t'(310);
      1:       return coef_t'(-1772);
      2:       return coef_t'(9654);
      default: return coef_t'(0);
    endcase
  endfunction

  // Strobes from the control sequencer to the datapath.
  typedef struct packed {
    logic shiftEn;   // accept a new sample into the delay line
    logic preAddEn;  // form symmetric pair sums on the kept phase
    logic mulEn;     // register the pair products and centre term
    logic outEn;     // load the rounded, clipped result
  } hb_ctl_t;

endpackage

// File: rtl/hb_ctrl.sv
module hb_ctrl (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output hb_pkg::hb_ctl_t  ctl,
  output logic             outValid
);

  logic phaseQ;      // 1 when the next accepted sample completes a pair
  logic fireQ;
  logic preValidQ;
  logic mulValidQ;
  logic outValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ    <= 1'b0;
      fireQ     <= 1'b0;
      preValidQ <= 1'b0;
      mulValidQ <= 1'b0;
      outValidQ <= 1'b0;
    end else begin
      if (inValid) phaseQ <= ~phaseQ;
      fireQ     <= inValid & phaseQ;
      preValidQ <= fireQ;
      mulValidQ <= preValidQ;
      outValidQ <= mulValidQ;
    end
  end

  always_comb begin
    ctl.shiftEn  = inValid;
    ctl.preAddEn = fireQ;
    ctl.mulEn    = preValidQ;
    ctl.outEn    = mulValidQ;
  end

  assign outValid = outValidQ;

  // R4: an output pulse lasts one cycle.
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValidQ |=> !outValidQ);

  // R5: every output pulse traces back to an accepted sample four cycles earlier.
  p_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValidQ |-> $past(inValid, 4));

  // R2: the first sample of a pair never starts a computation.
  p_first_of_pair_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !phaseQ) |=> !fireQ);

endmodule

// File: rtl/hb_datapath.sv
module hb_datapath #(
  parameter int DATA_W = 12,
  parameter int OUT_W  = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  hb_pkg::hb_ctl_t          ctl,
  input  logic signed [DATA_W-1:0] inData,
  output logic signed [OUT_W-1:0]  outData
);
  import hb_pkg::*;

  localparam int PRE_W  = DATA_W + 1;
  localparam int PROD_W = PRE_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(NPAIRS + 1) + 1;

  localparam logic signed [ACC_W-1:0] HALF_LSB =
    {{(ACC_W-COEF_FRAC){1'b0}}, 1'b1, {(COEF_FRAC-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] OUT_MAX =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] OUT_MIN =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [DATA_W-1:0] delayLine [NTAPS];
  logic signed [PRE_W-1:0]  preAddQ   [NPAIRS];
  logic signed [PROD_W-1:0] prodQ     [NPAIRS];
  logic signed [DATA_W-1:0] centreQ;
  logic signed [PROD_W-1:0] centreTermQ;

  logic signed [ACC_W-1:0] accSum;
  logic signed [ACC_W-1:0] rndSum;
  logic signed [ACC_W-1:0] rounded;
  logic signed [OUT_W-1:0] clipped;

  // Delay line: newest sample at index 0.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NTAPS; i++) delayLine[i] <= '0;
    end else if (ctl.shiftEn) begin
      delayLine[0] <= inData;
      for (int i = 1; i < NTAPS; i++) delayLine[i] <= delayLine[i-1];
    end
  end

  // Pre-add symmetric pairs, only on the kept phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NPAIRS; p++) preAddQ[p] <= '0;
      centreQ <= '0;
    end else if (ctl.preAddEn) begin
      for (int p = 0; p < NPAIRS; p++)
        preAddQ[p] <= PRE_W'(delayLine[2*p]) + PRE_W'(delayLine[NTAPS-1-2*p]);
      centreQ <= delayLine[CENTRE];
    end
  end

  // One multiply per pair; centre coefficient 1/2 is a shift.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NPAIRS; p++) prodQ[p] <= '0;
      centreTermQ <= '0;
    end else if (ctl.mulEn) begin
      for (int p = 0; p < NPAIRS; p++)
        prodQ[p] <= PROD_W'(preAddQ[p]) * PROD_W'(pairCoef(p));
      centreTermQ <= PROD_W'(centreQ) <<< (COEF_FRAC - 1);
    end
  end

  // Full-precision sum, half-up rounding, clipping.
  always_comb begin
    accSum = ACC_W'(centreTermQ);
    for (int p = 0; p < NPAIRS; p++) accSum = accSum + ACC_W'(prodQ[p]);
    rndSum  = accSum + HALF_LSB;
    rounded = rndSum >>> COEF_FRAC;
    if (rounded > OUT_MAX)      clipped = OUT_MAX[OUT_W-1:0];
    else if (rounded < OUT_MIN) clipped = OUT_MIN[OUT_W-1:0];
    else                        clipped = rounded[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          outData <= '0;
    else if (ctl.outEn) outData <= clipped;
  end

  // R8: an overflowing positive result lands on the upper limit.
  p_clip_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.outEn && (rounded > OUT_MAX)) |=> (outData == OUT_MAX[OUT_W-1:0]));

  // R8: an overflowing negative result lands on the lower limit.
  p_clip_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.outEn && (rounded < OUT_MIN)) |=> (outData == OUT_MIN[OUT_W-1:0]));

  // R2: the pair sums move only after a new sample has entered the line.
  p_preadd_follows_shift_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.preAddEn |-> $past(ctl.shiftEn));

endmodule

// File: rtl/hb_decim2.sv
module hb_decim2 #(
  parameter int DATA_W = 12,
  parameter int OUT_W  = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outData
);

  hb_pkg::hb_ctl_t ctl;

  hb_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  hb_datapath #(.DATA_W(DATA_W), .OUT_W(OUT_W)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inData  (inData),
    .outData (outData)
  );

  // R6: between pulses the output word is held.
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));

  // R1: nothing is emitted on the first cycle after reset.
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (!outValid && (outData == '0)));

endmodule

// File: tb/test_hb_decim2.sv
module test_hb_decim2;

  localparam int DATA_W = 12;
  localparam int OUT_W  = 12;
  localparam int NT     = 11;
  localparam int OMAX   = (1 <<< (OUT_W - 1)) - 1;
  localparam int OMIN   = -(1 <<< (OUT_W - 1));
  localparam int DMAX   = (1 <<< (DATA_W - 1)) - 1;
  localparam int DMIN   = -(1 <<< (DATA_W - 1));

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [DATA_W-1:0] inData = '0;
  logic outValid;
  logic signed [OUT_W-1:0] outData;

  always #2 clk = ~clk;   // 250 MHz

  hb_decim2 #(.DATA_W(DATA_W), .OUT_W(OUT_W)) i_hb_decim2 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;
  int acceptCount = 0;
  int outCount    = 0;
  bit dcPhase     = 0;
  bit done        = 0;
  int h    [NT];
  int hist [NT];
  int expQ [$];
  int dueQ [$];
  string tagQ [$];
  int lastOut = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int got, input int exp);
    nTests++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // Reference model from the requirement text (R3, R7, R8, R9).
  task automatic modelAccept(input int v);
    longint s;
    int r;
    int rc;
    bit allEq;
    string tag;
    for (int j = NT - 1; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = v;
    acceptCount++;
    if (acceptCount % 2 == 0) begin
      s = 0;
      for (int j = 0; j < NT; j++) s += longint'(h[j]) * longint'(hist[j]);
      r = int'((s + 16384) >>> 15);
      rc = (r > OMAX) ? OMAX : (r < OMIN) ? OMIN : r;
      allEq = 1;
      for (int j = 1; j < NT; j++) if (hist[j] != hist[0]) allEq = 0;
      if (rc != r)                  tag = "R8";
      else if ((s & 32767) == 16384) tag = "R7";
      else if (dcPhase && allEq)     tag = "R9";
      else                           tag = "R3";
      expQ.push_back(rc);
      dueQ.push_back(cyc + 4);
      tagQ.push_back(tag);
    end
  endtask

  // Drive at a falling edge; the sample is accepted at the next rising edge.
  task automatic sendSample(input int v, input int gap);
    inValid = 1'b1;
    inData  = v[DATA_W-1:0];
    modelAccept(v);
    @(negedge clk);
    inValid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic padToOdd();
    if (acceptCount % 2 == 0) sendSample(0, 0);
  endtask

  // Output monitor, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        outCount++;
        if (expQ.size() == 0) begin
          check("R2 unexpected output", 1, 0);
        end else begin
          check({tagQ[0], " data"}, int'(outData), expQ[0]);
          check("R5 timing", cyc, dueQ[0]);
          void'(expQ.pop_front());
          void'(dueQ.pop_front());
          void'(tagQ.pop_front());
        end
        lastOut = int'(outData);
      end else begin
        if (dueQ.size() != 0 && dueQ[0] == cyc) check("R5 missing pulse", 0, 1);
        if (int'(outData) != lastOut) check("R6 hold", int'(outData), lastOut);
      end
    end
  end

  // R4: no two consecutive pulses.
  logic prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid && prevValid) check("R4 pulse width", 2, 1);
      prevValid <= outValid;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : stim
    int v;
    int vec [NT];
    h = '{310, 0, -1772, 0, 9654, 16384, 9654, 0, -1772, 0, 310};
    for (int j = 0; j < NT; j++) hist[j] = 0;

    // R1: reset state
    repeat (4) @(negedge clk);
    check("R1 outValid in reset", int'(outValid), 0);
    check("R1 outData in reset", int'(outData), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outValid after reset", int'(outValid), 0);
    check("R1 outData after reset", int'(outData), 0);

    // R3: impulses on both parities
    sendSample(1000, 0);
    for (int i = 0; i < 13; i++) sendSample(0, 0);
    sendSample(0, 0);
    sendSample(-1000, 0);
    for (int i = 0; i < 12; i++) sendSample(0, 0);
    sendSample(777, 1);
    for (int i = 0; i < 12; i++) sendSample(0, 2);

    // R7: exact half-way fractions through the centre tap
    sendSample(1, 0);
    for (int i = 0; i < 12; i++) sendSample(0, 0);
    sendSample(-1, 0);
    for (int i = 0; i < 12; i++) sendSample(0, 0);
    sendSample(0, 0);
    sendSample(1, 0);
    for (int i = 0; i < 12; i++) sendSample(0, 0);
    sendSample(0, 0);
    sendSample(-1, 0);
    for (int i = 0; i < 12; i++) sendSample(0, 0);

    // R9: constant inputs
    dcPhase = 1;
    for (int i = 0; i < 16; i++) sendSample(DMAX, 0);
    for (int i = 0; i < 16; i++) sendSample(DMIN, 1);
    for (int i = 0; i < 16; i++) sendSample(300, 0);
    dcPhase = 0;

    // R8: sign-matched full scale, both directions
    for (int j = 0; j < NT; j++) vec[j] = (h[j] >= 0) ? DMAX : DMIN;
    padToOdd();
    for (int j = NT - 1; j >= 0; j--) sendSample(vec[j], 0);
    padToOdd();
    for (int j = NT - 1; j >= 0; j--) sendSample((vec[j] == DMAX) ? DMIN : DMAX, 0);
    for (int i = 0; i < 12; i++) sendSample(0, 0);

    // Full-scale alternation and random streams with gaps
    for (int i = 0; i < 40; i++) sendSample((i % 2 == 0) ? DMAX : DMIN, 0);
    for (int i = 0; i < 600; i++) begin
      v = int'($urandom_range(4095)) - 2048;
      sendSample(v, int'($urandom_range(2)));
    end

    repeat (12) @(negedge clk);
    done = 1;
    // R2: one output per two accepted samples, none outstanding
    check("R2 output count", outCount, acceptCount / 2);
    check("R2 pending outputs", expQ.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule